// File: doc/BRIEF.md
# Supply-Valid Reset and Brownout Gate

This block watches two supply comparator flags and decides when the rest of the chip may run. One flag says the supply sits above the turn-on level (1.1 V). The other says it has fallen below the turn-off level (1.05 V). The gap between the two levels gives hysteresis. The block leaves everything off until the supply has stayed good for a long settle window. This window absorbs power-switch bounce at start-up. After that, it opens the serial-interface enable and the speaker-driver gate, and it releases the active-low reset / low-battery line.

While the system is up, only the turn-off flag matters. A dip that ends inside a short rejection window is ignored. A dip that lasts past that window closes the driver gate, disables the interface and pulls the low-battery line low. Getting back up then takes the full settle window again. An active-low external reset / power-down pin clears everything asynchronously. Both comparator flags are resynchronised through two flops before any counter uses them. Both windows are given in clock cycles. At a 1.28 MHz clock, 100 ms is 128000 cycles and 44 µs is 56 cycles.

Top module: `supply_guard`

## Requirements
- R1: While `ext_rst_n` is low, `intf_en`, `drive_en` and `rst_lowbat_n` are all 0, and they drop to 0 without waiting for a clock edge.
- R2: Call the first rising clock edge that samples `above_on`=1 with `below_off`=0 edge 1. If both inputs hold these values, all three outputs are still 0 after edge SETTLE_CYCLES+1 and are 1 after edge SETTLE_CYCLES+2.
- R3: While the block is down, each clock sample with `above_on`=0 or `below_off`=1 restarts the settle window. A good-supply run of fewer than SETTLE_CYCLES samples never raises the outputs.
- R4: While the block is up, a run of `below_off`=1 samples shorter than DIP_CYCLES leaves all three outputs at 1 on every cycle.
- R5: While the block is up, a run of DIP_CYCLES or more `below_off`=1 samples starting at edge 1 drives all three outputs to 0 after edge DIP_CYCLES+2. They are still 1 after edge DIP_CYCLES+1.
- R6: After a brownout, the outputs come back only after a complete new settle window. If the supply is restored before edge r, the outputs return after edge r+SETTLE_CYCLES+1.
- R7: While the block is up, `above_on` going to 0 with `below_off` held at 0 has no effect on the outputs.
- R8: `intf_en`, `drive_en` and `rst_lowbat_n` always carry the same value. A 0 on `rst_lowbat_n` means the block is either in reset or in a brownout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock that times both windows |
| ext_rst_n | input | 1 | External reset / power-down, active low, asynchronous |
| above_on | input | 1 | Comparator flag: supply above the turn-on level |
| below_off | input | 1 | Comparator flag: supply below the turn-off level |
| intf_en | output | 1 | Serial-interface enable |
| drive_en | output | 1 | Output-driver gate |
| rst_lowbat_n | output | 1 | Reset / low-battery indication, active low |

## Verification
The bench builds the block with SETTLE_CYCLES=20 and DIP_CYCLES=4, so every window edge is only a few dozen cycles away. With these values it can sweep every bounce length that is one cycle short of the window, and every dip length from 1 to DIP_CYCLES+3. For each case it predicts the exact edge at which the outputs change. It also covers asynchronous reset in the middle of operation, the time-zero reset, and loss of the turn-on flag while the block is up.

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int unsigned SETTLE_CYCLES = 128000,
  parameter int unsigned DIP_CYCLES    = 56
) (
  input  logic clk,
  input  logic ext_rst_n,
  input  logic above_on,
  input  logic below_off,
  output logic intf_en,
  output logic drive_en,
  output logic rst_lowbat_n
);
  localparam int unsigned SW = $clog2(SETTLE_CYCLES + 1);
  localparam int unsigned DW = $clog2(DIP_CYCLES + 1);

  logic [1:0]    on_q, off_q;
  logic [SW-1:0] settle_q;
  logic [DW-1:0] dip_q;
  logic          up_q;

  wire on_s        = on_q[1];
  wire off_s       = off_q[1];
  wire supply_good = on_s && !off_s;
  wire settle_done = settle_q == SW'(SETTLE_CYCLES - 1);
  wire dip_done    = dip_q == DW'(DIP_CYCLES - 1);

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      on_q  <= '0;
      off_q <= '0;
    end else begin
      on_q  <= {on_q[0], above_on};
      off_q <= {off_q[0], below_off};
    end
  end

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      settle_q <= '0;
      dip_q    <= '0;
      up_q     <= 1'b0;
    end else if (!up_q) begin
      dip_q <= '0;
      if (!supply_good)     settle_q <= '0;
      else if (settle_done) begin
        settle_q <= '0;
        up_q     <= 1'b1;
      end else              settle_q <= settle_q + 1'b1;
    end else begin
      settle_q <= '0;
      if (!off_s)        dip_q <= '0;
      else if (dip_done) begin
        dip_q <= '0;
        up_q  <= 1'b0;
      end else           dip_q <= dip_q + 1'b1;
    end
  end

  assign intf_en      = up_q;
  assign drive_en     = up_q;
  assign rst_lowbat_n = up_q;
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
  parameter int unsigned SETTLE_CYCLES = 128000,
  parameter int unsigned DIP_CYCLES    = 56
) (
  input logic clk,
  input logic ext_rst_n,
  input logic above_on,
  input logic below_off,
  input logic intf_en,
  input logic drive_en,
  input logic rst_lowbat_n
);
  localparam int unsigned RW = $clog2(DIP_CYCLES + 3);
  localparam logic [RW-1:0] RMAX = RW'(DIP_CYCLES + 2);

  logic [RW-1:0] low_run;

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n)      low_run <= '0;
    else if (!below_off) low_run <= '0;
    else if (low_run != RMAX) low_run <= low_run + 1'b1;
  end

  assert_rise_needs_good_supply_R2: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(intf_en) |-> ($past(above_on, 3) && !$past(below_off, 3)));

  assert_fall_needs_long_dip_R4: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $fell(intf_en) |-> ($past(low_run, 2) >= RW'(DIP_CYCLES)));

  assert_sustained_dip_gates_R5: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (low_run == RMAX) |-> !intf_en);

  assert_outputs_agree_R8: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (drive_en == intf_en) && (rst_lowbat_n == intf_en));

  assert_fall_after_low_flag_R5: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $fell(drive_en) |-> $past(below_off, 3));
endmodule

bind supply_guard supply_guard_chk #(
  .SETTLE_CYCLES(SETTLE_CYCLES),
  .DIP_CYCLES(DIP_CYCLES)
) u_chk (
  .clk(clk),
  .ext_rst_n(ext_rst_n),
  .above_on(above_on),
  .below_off(below_off),
  .intf_en(intf_en),
  .drive_en(drive_en),
  .rst_lowbat_n(rst_lowbat_n)
);

// File: tb/test_supply_guard.sv
module test_supply_guard;
  localparam int SETTLE = 20;
  localparam int DIP    = 4;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic ext_rst_n = 1'b0;
  logic above_on = 1'b0;
  logic below_off = 1'b0;
  logic intf_en, drive_en, rst_lowbat_n;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  supply_guard #(.SETTLE_CYCLES(SETTLE), .DIP_CYCLES(DIP)) i_supply_guard (
    .clk(clk), .ext_rst_n(ext_rst_n), .above_on(above_on), .below_off(below_off),
    .intf_en(intf_en), .drive_en(drive_en), .rst_lowbat_n(rst_lowbat_n)
  );

  task automatic chk(input bit exp, input string req);
    logic [2:0] got;
    got = {intf_en, drive_en, rst_lowbat_n};
    n_vec++;
    if (got !== {3{exp}}) begin
      n_bad++;
      $display("FAIL %s at %0t: outputs=%b expected=%b", req, $time, got, {3{exp}});
    end
  endtask

  task automatic idle_down(input int n);
    above_on = 1'b0; below_off = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bring_up(input string req);
    above_on = 1'b1; below_off = 1'b0;
    repeat (SETTLE + 1) @(posedge clk);
    @(negedge clk); chk(1'b0, req);
    @(posedge clk);
    @(negedge clk); chk(1'b1, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(1'b0, "R1 time-zero reset");
    ext_rst_n = 1'b1;
    idle_down(4);
    chk(1'b0, "R1 released but unqualified");

    // R3: bounce pulses one cycle short of the window never qualify
    for (int len = 1; len < SETTLE; len++) begin
      above_on = 1'b1;
      for (int t = 1; t <= len + 6; t++) begin
        @(posedge clk); @(negedge clk);
        if (t == len) above_on = 1'b0;
        chk(1'b0, "R3 bounce restarts window");
      end
      idle_down(3);
    end

    // R3: good run broken by a turn-off flag sample
    above_on = 1'b1;
    repeat (SETTLE - 2) @(posedge clk);
    @(negedge clk); below_off = 1'b1;
    @(posedge clk); @(negedge clk); below_off = 1'b0;
    repeat (SETTLE - 2) @(posedge clk);
    @(negedge clk); chk(1'b0, "R3 low flag restarts window");
    idle_down(3);

    bring_up("R2 exact settle latency");

    // R7: losing turn-on flag alone is ignored
    above_on = 1'b0;
    for (int t = 0; t < 30; t++) begin
      @(posedge clk); @(negedge clk);
      chk(1'b1, "R7 turn-on flag loss ignored");
    end
    above_on = 1'b1;

    // R4 / R5 / R6: dip length sweep
    for (int len = 1; len <= DIP + 3; len++) begin
      below_off = 1'b1; above_on = 1'b0;
      for (int t = 1; t <= len + SETTLE + 4; t++) begin
        bit exp;
        @(posedge clk); @(negedge clk);
        if (len < DIP) exp = 1'b1;
        else exp = !(t >= DIP + 2 && t < len + SETTLE + 2);
        if (len < DIP) chk(exp, "R4 short dip ignored");
        else if (t < len + 2) chk(exp, "R5 sustained dip gates");
        else chk(exp, "R6 full window to recover");
        if (t == len) begin below_off = 1'b0; above_on = 1'b1; end
      end
    end

    // R1: asynchronous external reset while up
    #1 ext_rst_n = 1'b0;
    #1 chk(1'b0, "R1 async power-down");
    @(posedge clk); @(negedge clk);
    chk(1'b0, "R1 held in power-down");
    ext_rst_n = 1'b1;
    bring_up("R2 after external reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule